// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Gating Controller

This controller decides which outputs of a multi-output clock generator may run. After power-on reset it waits for a power-good level on a shared pin. When that level arrives, it captures the configuration straps that the board presents on other shared pins, and then hands those pins back to the clock drivers. The captured mode strap decides whether one PCI-group pin becomes a stop input or stays a clock output. The power-good pin itself then becomes an active-low stop for the CPU clocks.

Stop requests are synchronised into the reference clock domain. A group's enable changes only while that group's clock is sampled low, so a running pulse is never cut short. A programmable watchdog counts reference cycles and is reloaded by every register write. When it expires while enabled, it drives a fixed-length active-low reset pulse and then re-arms itself.

Top module: `clkgen_ctrl`

## Requirements
- R1: After reset and until the straps are captured, `straps_valid`, `strap_oe`, `pci8_oe`, `cpu_en`, `pci_en`, `pcif_en` and `other_en` are all 0, and strap pin activity has no effect.
- R2: The straps are captured from `strap_in` on the third rising edge after `pg_stop_n` goes high (two synchroniser stages, then the capture register). The bit layout is: bits 3..0 frequency select, bit 4 CPU current multiplier, bit 5 HTT current multiplier, bit 6 mode, bit 7 SEL24_48. Later changes of `strap_in`, and later power-good transitions, do not change `straps_q` until the next reset.
- R3: Once the straps are captured, `strap_oe` and `other_en` are 1, and `pcif_en` is 1 at its next update. All three then stay 1 whatever `pg_stop_n` and `pci_stop_pin` do.
- R4: After capture, `pg_stop_n` acts as an active-low CPU stop. `cpu_en` follows the level of `pg_stop_n` with three cycles of latency.
- R5: With mode bit 6 = 1, `pci8_oe` is 0, and a low on `pci_stop_pin` clears `pci_en` with three cycles of latency. `pcif_en` is not affected.
- R6: With mode bit 6 = 0, `pci8_oe` is 1 after capture, and `pci_stop_pin` has no effect on `pci_en`.
- R7: `cpu_en` can change only at an edge where `cpu_phase` is 0. `pci_en` and `pcif_en` can change only at an edge where `pci_phase` is 0.
- R8: `sel24` (1 = 24 MHz, 0 = 48 MHz) equals captured bit 7. While `sel_ovr_en` is 1, it equals `sel_ovr_val` instead.
- R9: L edges after the edge that samples `reg_wr` with `wd_load` = L, the watchdog expires. `wd_rst_n` then goes low for exactly PULSE_CYC cycles, but only if `wd_en` is 1 at expiry. Otherwise it stays high.
- R10: The watchdog reloads L when a pulse ends and expires again L cycles later. Writes spaced closer than L keep it from ever expiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low power-on reset |
| pg_stop_n | input | 1 | Power-good level, later active-low CPU stop |
| pci_stop_pin | input | 1 | Level on the shared PCI stop/clock pin |
| strap_in | input | 8 | Raw strap pin levels |
| cpu_phase | input | 1 | Sampled level of the CPU group clock |
| pci_phase | input | 1 | Sampled level of the PCI group clock |
| reg_wr | input | 1 | Register write strobe, reloads watchdog |
| wd_load | input | WD_W | Watchdog timeout in reference cycles |
| wd_en | input | 1 | Watchdog reset output enable bit |
| sel_ovr_en | input | 1 | Register override of 24/48 selection active |
| sel_ovr_val | input | 1 | Register value for 24/48 selection |
| straps_q | output | 8 | Captured straps |
| straps_valid | output | 1 | Straps have been captured |
| strap_oe | output | 1 | Strap pins driven as outputs |
| pci8_oe | output | 1 | Shared PCI pin driven as clock output |
| cpu_en | output | 1 | CPU clock group enable |
| pci_en | output | 1 | Stoppable PCI clock group enable |
| pcif_en | output | 1 | Free-running PCI clock enable |
| other_en | output | 1 | Enable for remaining outputs |
| sel24 | output | 1 | 24/48 output selects 24 MHz |
| wd_rst_n | output | 1 | Active-low watchdog reset pulse |

## Verification
The hardest case to reach is a stop request that arrives while the group clock is high. The bench must show that the enable holds its old value and only follows the request once the phase goes low. The vector table first sets a known enable state. It then changes the stop levels while both phase inputs are high, and only lowers the phases in a later vector. The same table also holds the PCI phase high alone while the CPU phase is low, which separates the two groups. A second reset with the mode strap cleared covers the clock-output variant of the shared pin.

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl #(
  parameter int WD_W      = 16,
  parameter int PULSE_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_stop_n,
  input  logic            pci_stop_pin,
  input  logic [7:0]      strap_in,
  input  logic            cpu_phase,
  input  logic            pci_phase,
  input  logic            reg_wr,
  input  logic [WD_W-1:0] wd_load,
  input  logic            wd_en,
  input  logic            sel_ovr_en,
  input  logic            sel_ovr_val,
  output logic [7:0]      straps_q,
  output logic            straps_valid,
  output logic            strap_oe,
  output logic            pci8_oe,
  output logic            cpu_en,
  output logic            pci_en,
  output logic            pcif_en,
  output logic            other_en,
  output logic            sel24,
  output logic            wd_rst_n
);
  localparam int PW       = $clog2(PULSE_CYC + 1);
  localparam int MODE_BIT = 6;
  localparam int SEL_BIT  = 7;

  logic [1:0]      pg_sync, ps_sync;
  logic            latched;
  logic [WD_W-1:0] wd_cnt;
  logic [PW-1:0]   pls;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_sync <= 2'b00;
      ps_sync <= 2'b11;
    end else begin
      pg_sync <= {pg_sync[0], pg_stop_n};
      ps_sync <= {ps_sync[0], pci_stop_pin};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latched  <= 1'b0;
      straps_q <= '0;
    end else if (!latched && pg_sync[1]) begin
      latched  <= 1'b1;
      straps_q <= strap_in;
    end

  wire mode    = straps_q[MODE_BIT];
  wire cpu_req = latched & pg_sync[1];
  wire pci_req = latched & ~(mode & ~ps_sync[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_en  <= 1'b0;
      pci_en  <= 1'b0;
      pcif_en <= 1'b0;
    end else begin
      if (!cpu_phase) cpu_en <= cpu_req;
      if (!pci_phase) begin
        pci_en  <= pci_req;
        pcif_en <= latched;
      end
    end

  assign straps_valid = latched;
  assign strap_oe     = latched;
  assign other_en     = latched;
  assign pci8_oe      = latched & ~mode;
  assign sel24        = sel_ovr_en ? sel_ovr_val : straps_q[SEL_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_cnt <= '0;
      pls    <= '0;
    end else begin
      if (pls != '0) pls <= pls - PW'(1);
      if (reg_wr)
        wd_cnt <= wd_load;
      else if (wd_cnt == WD_W'(1)) begin
        wd_cnt <= '0;
        if (wd_en) pls <= PW'(PULSE_CYC);
      end else if (wd_cnt != '0)
        wd_cnt <= wd_cnt - WD_W'(1);
      else if (pls == PW'(1))
        wd_cnt <= wd_load;
    end

  assign wd_rst_n = (pls == '0);
endmodule

// File: rtl/clkgen_ctrl_chk.sv
module clkgen_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pg_stop_n,
  input logic       pci_stop_pin,
  input logic       cpu_phase,
  input logic       pci_phase,
  input logic       wd_en,
  input logic [7:0] straps_q,
  input logic       straps_valid,
  input logic       strap_oe,
  input logic       pci8_oe,
  input logic       cpu_en,
  input logic       pci_en,
  input logic       pcif_en,
  input logic       other_en,
  input logic       wd_rst_n
);
  p_pre_latch_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !straps_valid |-> !cpu_en && !pci_en && !pcif_en && !other_en && !strap_oe && !pci8_oe);

  p_straps_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid |=> straps_valid && $stable(straps_q));

  p_cpu_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(straps_valid) && !$past(pg_stop_n, 3) && !$past(cpu_phase) |-> !cpu_en);

  p_pci_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(straps_valid) && $past(straps_q[6]) && !$past(pci_stop_pin, 3) && !$past(pci_phase)
    |-> !pci_en && pcif_en);

  p_mode0_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid && !straps_q[6] |-> pci8_oe);

  p_cpu_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_phase |=> $stable(cpu_en));

  p_pci_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pci_phase |=> $stable(pci_en) && $stable(pcif_en));

  p_wd_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_n) |-> $past(wd_en));
endmodule

bind clkgen_ctrl clkgen_ctrl_chk u_chk (.*);

// File: tb/clkgen_ctrl_test.sv
`timescale 1ns/1ps
module clkgen_ctrl_test;
  localparam int WD_W = 8;
  localparam int P    = 4;
  localparam int L    = 5;

  logic clk = 0, rst_n = 0, pg_stop_n = 0, pci_stop_pin = 1;
  logic [7:0] strap_in = 8'hC5;
  logic cpu_phase = 0, pci_phase = 0, reg_wr = 0, wd_en = 0;
  logic sel_ovr_en = 0, sel_ovr_val = 0;
  logic [WD_W-1:0] wd_load = WD_W'(L);
  logic [7:0] straps_q;
  logic straps_valid, strap_oe, pci8_oe, cpu_en, pci_en, pcif_en, other_en, sel24, wd_rst_n;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  clkgen_ctrl #(.WD_W(WD_W), .PULSE_CYC(P)) uut (.*);

  // fields: pg, pci_stop, cpu_phase, pci_phase, exp cpu_en, exp pci_en
  localparam logic [5:0] VEC [6] = '{6'b010001, 6'b100010, 6'b001110,
                                     6'b000000, 6'b110110, 6'b110011};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pulse();
    reg_wr = 1;
    step(1);
    reg_wr = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    strap_in = 8'h3A;
    pci_stop_pin = 0;
    step(4);
    chk("R1 valid before pg", {31'b0, straps_valid}, 0);
    chk("R1 enables before pg", {28'b0, cpu_en, pci_en, pcif_en, other_en}, 0);
    chk("R1 oe before pg", {30'b0, strap_oe, pci8_oe}, 0);
    chk("R9 wd idle", {31'b0, wd_rst_n}, 1);

    strap_in = 8'hC5;
    pci_stop_pin = 1;
    pg_stop_n = 1;
    step(2);
    chk("R2 not yet captured", {31'b0, straps_valid}, 0);
    step(1);
    chk("R2 captured third edge", {31'b0, straps_valid}, 1);
    chk("R2 strap value", {24'b0, straps_q}, 32'hC5);
    chk("R3 strap_oe", {31'b0, strap_oe}, 1);
    chk("R5 pci8_oe mode1", {31'b0, pci8_oe}, 0);
    step(1);
    chk("R3 enables on", {28'b0, cpu_en, pci_en, pcif_en, other_en}, 4'hF);
    strap_in = 8'h3A;
    step(3);
    chk("R2 strap change ignored", {24'b0, straps_q}, 32'hC5);

    foreach (VEC[i]) begin
      pg_stop_n = VEC[i][5];
      pci_stop_pin = VEC[i][4];
      cpu_phase = VEC[i][3];
      pci_phase = VEC[i][2];
      step(4);
      chk($sformatf("R4 R7 cpu_en vec%0d", i), {31'b0, cpu_en}, {31'b0, VEC[i][1]});
      chk($sformatf("R5 R7 pci_en vec%0d", i), {31'b0, pci_en}, {31'b0, VEC[i][0]});
      chk($sformatf("R3 pcif other vec%0d", i), {30'b0, pcif_en, other_en}, 3);
    end
    chk("R2 no relatch", {24'b0, straps_q}, 32'hC5);

    chk("R8 sel24 strap", {31'b0, sel24}, 1);
    sel_ovr_en = 1;
    sel_ovr_val = 0;
    step(1);
    chk("R8 override 48", {31'b0, sel24}, 0);
    sel_ovr_val = 1;
    step(1);
    chk("R8 override 24", {31'b0, sel24}, 1);
    sel_ovr_en = 0;

    wd_en = 0;
    wr_pulse();
    begin
      int hi = 0;
      for (int m = 0; m < 2 * L + 2 * P; m++) begin
        hi += wd_rst_n;
        step(1);
      end
      chk("R9 no pulse when disabled", hi, 2 * L + 2 * P);
    end

    wd_en = 1;
    wr_pulse();
    for (int m = 0; m < 2 * L + 2 * P; m++) begin
      logic exp_low;
      exp_low = (m >= L && m < L + P) || (m >= 2 * L + P && m < 2 * L + 2 * P);
      chk($sformatf("R9 R10 wd_rst_n m=%0d", m), {31'b0, wd_rst_n}, {31'b0, ~exp_low});
      step(1);
    end

    rst_n = 0;
    step(1);
    rst_n = 1;
    wd_en = 1;
    begin
      int lows = 0;
      for (int k = 0; k < 8; k++) begin
        wr_pulse();
        lows += !wd_rst_n;
        step(2);
        lows += !wd_rst_n;
      end
      chk("R10 writes keep reloading", lows, 0);
    end
    wd_en = 0;

    rst_n = 0;
    pg_stop_n = 0;
    strap_in = 8'h0A;
    step(2);
    rst_n = 1;
    step(1);
    pg_stop_n = 1;
    pci_stop_pin = 0;
    step(5);
    chk("R6 pci8_oe mode0", {31'b0, pci8_oe}, 1);
    chk("R6 stop pin ignored", {31'b0, pci_en}, 1);
    chk("R8 sel24 48 strap", {31'b0, sel24}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule